// File: doc/BRIEF.md
# Broadcast-Input Dense Layer with Rectifier

This block evaluates one fully connected neural-network layer in signed fixed point. A host loads a weight matrix, a bias vector and an input vector into local storage, then pulses `start`. The block streams the input elements one at a time. Each element is handed in the same cycle to a bank of multiply-accumulate lanes, one lane per output. So every output's running sum advances together, and a run takes one cycle per input element plus two cycles of overhead.

Each lane is seeded with its bias before the first input element arrives. After the last input element, every sum is scaled down by an arithmetic right shift, optionally clipped at zero, saturated to the output width and registered. A one-cycle `done` pulse then reports that the new output vector is valid. The weights and biases can be rewritten between runs, for example after retraining. A parameter removes the zero clip, so the same block can serve as a hidden layer with a rectifier or as the final layer that emits raw class scores.

Top module: `dense_bcast_fc`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears its state: after that edge `busy` and `done` are 0 and every lane of `y` is 0.
- R2: At a rising edge where `w_we` is high, the block stores `w_data` as the weight that links input `w_in_sel` to output `w_out_sel`. `b_we` stores `b_data` as the bias of output `b_sel` in the same way, and `x_we` stores `x_data` as input element `x_sel`. The next run uses the stored values.
- R3: The pre-scaling sum of output o is the bias of o plus the sum over all inputs i of weight(i,o) times x(i). All values are signed two's complement. The accumulator is wide enough that this sum never wraps.
- R4: Output o is the sum from R3 shifted right arithmetically by `SHIFT` bits (rounding toward minus infinity), then saturated to the signed `DW`-bit range. Lane o occupies `y[o*DW +: DW]`.
- R5: With `RELU_EN`=1, a negative sum produces output 0. With `RELU_EN`=0, negative results pass through the scaling and saturation of R4 unchanged.
- R6: A `start` sampled high while `busy` is low begins a run. `busy` is high from the next cycle on. `done` is high for exactly one cycle, the one after the (N_IN+1)-th rising edge that follows the accepting edge. `busy` is low in that same cycle.
- R7: A `start` sampled while `busy` is high is ignored. It neither restarts nor lengthens the current run, and it does not change its result.
- R8: `y` changes only in the cycle in which `done` is high, and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| w_we | input | 1 | Weight write enable |
| w_in_sel | input | $clog2(N_IN) | Input index of the weight being written |
| w_out_sel | input | $clog2(N_OUT) | Output index of the weight being written |
| w_data | input | WW | Signed weight value |
| b_we | input | 1 | Bias write enable |
| b_sel | input | $clog2(N_OUT) | Output index of the bias being written |
| b_data | input | BW | Signed bias, in product scale |
| x_we | input | 1 | Input element write enable |
| x_sel | input | $clog2(N_IN) | Index of the input element being written |
| x_data | input | DW | Signed input element |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: new outputs valid |
| y | output | N_OUT*DW | Output vector, lane o at bits o*DW +: DW |

## Verification
The assertions take for granted that the host leaves the weight, bias and input stores alone while `busy` is high. A write during a run would make the result depend on the write's timing, and neither the latency check nor the rectifier check could then tie `done` to a defined sum. They also assume that `start` is a plain level sampled on the clock and that its timing may be arbitrary. The stimulus therefore makes every buffer write with `busy` low and waits for `done` before the next load. It deliberately raises `start` in the middle of a run to exercise the ignore rule.

// File: rtl/fcl_pkg.sv
// Package: shared types for the broadcast-input dense layer.
// Assumes nothing beyond being compiled before the modules that import it.
package fcl_pkg;

    // Sequencer phases: idle, broadcast/accumulate, result commit.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACC   = 2'd1,
        ST_WRITE = 2'd2
    } fcl_state_t;

endpackage

// File: rtl/fcl_ctrl.sv
// Sequencer: accepts start when idle, seeds the lanes with bias, walks the
// input index from 0 to N_IN-1 (one element per cycle), then commits the
// results and pulses done. Assumes N_IN >= 2.
module fcl_ctrl
    import fcl_pkg::*;
#(
    parameter  int N_IN  = 16,
    localparam int IN_AW = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load_bias,
    output logic             mac_en,
    output logic [IN_AW-1:0] rd_idx,
    output logic             commit,
    output logic             busy,
    output logic             done
);

    localparam logic [IN_AW-1:0] LAST_IDX = IN_AW'(N_IN - 1);

    fcl_state_t       st_q;
    logic [IN_AW-1:0] idx_q;
    logic             done_q;

    // Decode phase strobes from the current state.
    assign busy      = (st_q != ST_IDLE);
    assign load_bias = (st_q == ST_IDLE) && start;
    assign mac_en    = (st_q == ST_ACC);
    assign commit    = (st_q == ST_WRITE);
    assign rd_idx    = idx_q;
    assign done      = done_q;

    // Advance the phase and the broadcast index; done follows commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (st_q == ST_WRITE);
            case (st_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (start) st_q <= ST_ACC;
                end
                ST_ACC: begin
                    if (idx_q == LAST_IDX) st_q <= ST_WRITE;
                    else                   idx_q <= idx_q + 1'b1;
                end
                ST_WRITE: st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fcl_weight_buf.sv
// Weight store organised by input index: one read returns the whole column
// of N_OUT weights for that input, so all lanes are fed in one cycle. Writes
// are element-wise from the host. Storage is not reset (the host loads it).
module fcl_weight_buf #(
    parameter  int N_IN   = 16,
    parameter  int N_OUT  = 10,
    parameter  int WW     = 8,
    localparam int IN_AW  = $clog2(N_IN),
    localparam int OUT_AW = $clog2(N_OUT)
) (
    input  logic                clk,
    input  logic                we,
    input  logic [IN_AW-1:0]    wr_in,
    input  logic [OUT_AW-1:0]   wr_out,
    input  logic [WW-1:0]       wr_data,
    input  logic [IN_AW-1:0]    rd_idx,
    output logic [N_OUT*WW-1:0] col
);

    logic [WW-1:0] mem_q [N_IN][N_OUT];

    // Store one host-written weight element, ignoring out-of-range indices.
    always_ff @(posedge clk) begin
        if (we && int'(wr_in) < N_IN && int'(wr_out) < N_OUT)
            mem_q[wr_in][wr_out] <= wr_data;
    end

    // Present the column for the current broadcast index.
    for (genvar o = 0; o < N_OUT; o++) begin : g_col
        assign col[o*WW +: WW] = mem_q[rd_idx][o];
    end

endmodule

// File: rtl/fcl_mac_bank.sv
// Bank of N_OUT multiply-accumulate lanes. Every lane receives the same
// broadcast input element and its own weight from the column. A load seeds
// each accumulator with its sign-extended bias. Assumes ACCW is wide enough
// for bias plus N_IN full-scale products.
module fcl_mac_bank #(
    parameter int N_OUT = 10,
    parameter int DW    = 8,
    parameter int WW    = 8,
    parameter int BW    = 16,
    parameter int ACCW  = 22
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  mac_en,
    input  logic [N_OUT*BW-1:0]   bias_flat,
    input  logic signed [DW-1:0]  x,
    input  logic [N_OUT*WW-1:0]   w_col,
    output logic [N_OUT*ACCW-1:0] acc_flat
);

    localparam int PW = DW + WW;

    for (genvar o = 0; o < N_OUT; o++) begin : g_lane
        logic signed [WW-1:0]   w;
        logic signed [PW-1:0]   prod;
        logic signed [ACCW-1:0] acc_q;

        assign w    = $signed(w_col[o*WW +: WW]);
        assign prod = w * x;
        assign acc_flat[o*ACCW +: ACCW] = acc_q;

        // Seed with bias on load, otherwise add this lane's product.
        always_ff @(posedge clk) begin
            if (!rst_n)      acc_q <= '0;
            else if (load)   acc_q <= ACCW'($signed(bias_flat[o*BW +: BW]));
            else if (mac_en) acc_q <= acc_q + ACCW'(prod);
        end
    end

endmodule

// File: rtl/fcl_post.sv
// Output stage: per lane, optional zero clip, arithmetic scale-down by SHIFT,
// saturation to DW signed bits, and a register loaded only on commit.
module fcl_post #(
    parameter int N_OUT   = 10,
    parameter int DW      = 8,
    parameter int ACCW    = 22,
    parameter int SHIFT   = 4,
    parameter bit RELU_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic [N_OUT*ACCW-1:0] acc_flat,
    output logic [N_OUT*DW-1:0]   y
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_lane
        logic signed [ACCW-1:0] a;
        logic signed [ACCW-1:0] r;
        logic signed [ACCW-1:0] s;
        logic [DW-1:0]          q;
        logic [DW-1:0]          y_q;

        assign a = $signed(acc_flat[o*ACCW +: ACCW]);

        if (RELU_EN) begin : g_relu
            assign r = a[ACCW-1] ? '0 : a;
        end else begin : g_pass
            assign r = a;
        end

        assign s = r >>> SHIFT;

        // Saturate: keep the value if the discarded upper bits are a sign run.
        always_comb begin
            if ((&s[ACCW-1:DW-1]) || !(|s[ACCW-1:DW-1])) q = s[DW-1:0];
            else if (s[ACCW-1])                          q = {1'b1, {(DW-1){1'b0}}};
            else                                         q = {1'b0, {(DW-1){1'b1}}};
        end

        // Hold the lane result until the next commit.
        always_ff @(posedge clk) begin
            if (!rst_n)      y_q <= '0;
            else if (commit) y_q <= q;
        end

        assign y[o*DW +: DW] = y_q;
    end

endmodule

// File: rtl/dense_bcast_fc.sv
// Top: fully connected layer with input broadcast. The host loads weights,
// biases and inputs while idle; start runs N_IN accumulate cycles in which
// input element i is multiplied by column i in all lanes at once. Assumes
// no buffer writes while busy, N_IN >= 2, N_OUT >= 2 and BW <= ACCW.
module dense_bcast_fc #(
    parameter  int N_IN    = 16,
    parameter  int N_OUT   = 10,
    parameter  int DW      = 8,
    parameter  int WW      = 8,
    parameter  int BW      = 16,
    parameter  int SHIFT   = 4,
    parameter  bit RELU_EN = 1'b1,
    localparam int IN_AW   = $clog2(N_IN),
    localparam int OUT_AW  = $clog2(N_OUT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                w_we,
    input  logic [IN_AW-1:0]    w_in_sel,
    input  logic [OUT_AW-1:0]   w_out_sel,
    input  logic [WW-1:0]       w_data,
    input  logic                b_we,
    input  logic [OUT_AW-1:0]   b_sel,
    input  logic [BW-1:0]       b_data,
    input  logic                x_we,
    input  logic [IN_AW-1:0]    x_sel,
    input  logic [DW-1:0]       x_data,
    input  logic                start,
    output logic                busy,
    output logic                done,
    output logic [N_OUT*DW-1:0] y
);

    localparam int ACCW = DW + WW + IN_AW + 2;

    logic [BW-1:0]          bias_q [N_OUT];
    logic [DW-1:0]          x_q    [N_IN];
    logic [N_OUT*BW-1:0]    bias_flat;
    logic [N_OUT*WW-1:0]    w_col;
    logic [N_OUT*ACCW-1:0]  acc_flat;
    logic [IN_AW-1:0]       rd_idx;
    logic                   load_bias;
    logic                   mac_en;
    logic                   commit;
    logic signed [DW-1:0]   x_cur;

    // Bias store, one entry per output lane (host loaded, not reset).
    always_ff @(posedge clk) begin
        if (b_we && int'(b_sel) < N_OUT) bias_q[b_sel] <= b_data;
    end

    // Input vector store, one entry per input element (host loaded, not reset).
    always_ff @(posedge clk) begin
        if (x_we && int'(x_sel) < N_IN) x_q[x_sel] <= x_data;
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_bias
        assign bias_flat[o*BW +: BW] = bias_q[o];
    end

    assign x_cur = $signed(x_q[rd_idx]);

    fcl_ctrl #(.N_IN(N_IN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_bias (load_bias),
        .mac_en    (mac_en),
        .rd_idx    (rd_idx),
        .commit    (commit),
        .busy      (busy),
        .done      (done)
    );

    fcl_weight_buf #(.N_IN(N_IN), .N_OUT(N_OUT), .WW(WW)) u_wbuf (
        .clk     (clk),
        .we      (w_we),
        .wr_in   (w_in_sel),
        .wr_out  (w_out_sel),
        .wr_data (w_data),
        .rd_idx  (rd_idx),
        .col     (w_col)
    );

    fcl_mac_bank #(.N_OUT(N_OUT), .DW(DW), .WW(WW), .BW(BW), .ACCW(ACCW)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_bias),
        .mac_en    (mac_en),
        .bias_flat (bias_flat),
        .x         (x_cur),
        .w_col     (w_col),
        .acc_flat  (acc_flat)
    );

    fcl_post #(.N_OUT(N_OUT), .DW(DW), .ACCW(ACCW), .SHIFT(SHIFT), .RELU_EN(RELU_EN)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .acc_flat (acc_flat),
        .y        (y)
    );

endmodule

// File: rtl/fcl_checks.sv
// Checker bound to dense_bcast_fc: handshake timing, output hold and the
// non-negative output rule. Counts cycles since an accepted start so the
// latency window needs no long $past.
module fcl_checks #(
    parameter int N_IN    = 16,
    parameter int N_OUT   = 10,
    parameter int DW      = 8,
    parameter bit RELU_EN = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [N_OUT*DW-1:0] y
);

    int   run_cnt;
    logic any_neg;

    // Count edges since the accepting edge of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt <= 0;
        else if (start && !busy) run_cnt <= 1;
        else if (busy)           run_cnt <= run_cnt + 1;
    end

    // Flag any lane whose sign bit is set.
    always_comb begin
        any_neg = 1'b0;
        for (int o = 0; o < N_OUT; o++) any_neg = any_neg | y[o*DW+DW-1];
    end

    p_busy_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == N_IN + 2));

    p_busy_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt <= N_IN + 1));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(y));

    if (RELU_EN) begin : g_relu_chk
        p_nonneg_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !any_neg);
    end

endmodule

bind dense_bcast_fc fcl_checks #(
    .N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .RELU_EN(RELU_EN)
) u_fcl_checks (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .y(y)
);

// File: tb/dense_bcast_fc_test.sv
`timescale 1ns/1ps
// Bench: a behavioural cycle model (integer arrays and a countdown) predicts
// busy, done and both output vectors; they are compared on every clock for a
// rectifying instance and a raw-score instance sharing the same inputs.
module dense_bcast_fc_test;

    localparam int N_IN  = 16;
    localparam int N_OUT = 10;
    localparam int DW    = 8;
    localparam int WW    = 8;
    localparam int BW    = 16;
    localparam int SHIFT = 4;
    localparam int IN_AW = $clog2(N_IN);
    localparam int OUT_AW = $clog2(N_OUT);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic w_we = 1'b0, b_we = 1'b0, x_we = 1'b0, start = 1'b0;
    logic [IN_AW-1:0]  w_in_sel = '0, x_sel = '0;
    logic [OUT_AW-1:0] w_out_sel = '0, b_sel = '0;
    logic [WW-1:0] w_data = '0;
    logic [BW-1:0] b_data = '0;
    logic [DW-1:0] x_data = '0;
    logic busy, done, busy_r, done_r;
    logic [N_OUT*DW-1:0] y, y_r;

    always #5 clk = ~clk;

    dense_bcast_fc #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .WW(WW), .BW(BW),
                     .SHIFT(SHIFT), .RELU_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .w_we(w_we), .w_in_sel(w_in_sel),
        .w_out_sel(w_out_sel), .w_data(w_data), .b_we(b_we), .b_sel(b_sel),
        .b_data(b_data), .x_we(x_we), .x_sel(x_sel), .x_data(x_data),
        .start(start), .busy(busy), .done(done), .y(y));

    dense_bcast_fc #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .WW(WW), .BW(BW),
                     .SHIFT(SHIFT), .RELU_EN(1'b0)) uut_raw (
        .clk(clk), .rst_n(rst_n), .w_we(w_we), .w_in_sel(w_in_sel),
        .w_out_sel(w_out_sel), .w_data(w_data), .b_we(b_we), .b_sel(b_sel),
        .b_data(b_data), .x_we(x_we), .x_sel(x_sel), .x_data(x_data),
        .start(start), .busy(busy_r), .done(done_r), .y(y_r));

    // Reference state
    int w_m [N_IN][N_OUT];
    int b_m [N_OUT];
    int x_m [N_IN];
    int exp_y [N_OUT];
    int exp_yr [N_OUT];
    int cnt = 0;
    bit exp_busy = 0, exp_done = 0, live = 0;
    string req_tag = "R3";
    int checks = 0, errors = 0, cyc = 0;
    int unsigned seed = 32'h1234_5678;

    function automatic int post(int a, bit relu);
        int lim;
        lim = 1 <<< (DW - 1);
        if (relu && a < 0) a = 0;
        a = a >>> SHIFT;
        if (a > lim - 1) a = lim - 1;
        if (a < -lim) a = -lim;
        return a;
    endfunction

    // Cycle model: mirrors the port-level behaviour in the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt = 0; exp_busy = 0; exp_done = 0; live = 1;
            for (int o = 0; o < N_OUT; o++) begin exp_y[o] = 0; exp_yr[o] = 0; end
        end else begin
            exp_done = 0;
            if (cnt > 0) begin
                cnt = cnt - 1;
                if (cnt == 0) begin
                    exp_busy = 0; exp_done = 1;
                    for (int o = 0; o < N_OUT; o++) begin
                        int acc;
                        acc = b_m[o];
                        for (int i = 0; i < N_IN; i++) acc = acc + w_m[i][o] * x_m[i];
                        exp_y[o]  = post(acc, 1'b1);
                        exp_yr[o] = post(acc, 1'b0);
                    end
                end
            end else if (start) begin
                exp_busy = 1; cnt = N_IN + 1;
            end
        end
        if (w_we) w_m[w_in_sel][w_out_sel] = int'($signed(w_data));
        if (b_we) b_m[b_sel] = int'($signed(b_data));
        if (x_we) x_m[x_sel] = int'($signed(x_data));
    end

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, expv, cyc);
        end
    endtask

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            string tb, ty;
            tb = !rst_n ? "R1" : "R6";
            ty = !rst_n ? "R1" : (exp_done ? req_tag : "R8");
            chk(busy == exp_busy, tb, "busy", int'(busy), int'(exp_busy));
            chk(done == exp_done, tb, "done", int'(done), int'(exp_done));
            chk(busy_r == exp_busy, tb, "busy raw", int'(busy_r), int'(exp_busy));
            chk(done_r == exp_done, tb, "done raw", int'(done_r), int'(exp_done));
            for (int o = 0; o < N_OUT; o++) begin
                int a, ar;
                a  = int'($signed(y[o*DW +: DW]));
                ar = int'($signed(y_r[o*DW +: DW]));
                chk(a == exp_y[o], ty, $sformatf("y[%0d] relu", o), a, exp_y[o]);
                chk(ar == exp_yr[o], (ty == req_tag && exp_done) ? "R5" : ty,
                    $sformatf("y[%0d] raw", o), ar, exp_yr[o]);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R6 watchdog: cycles %0d expected below %0d", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int rnd(int span);
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'((seed >> 8) % (2 * span)) - span;
    endfunction

    task automatic put_w(int i, int o, int v);
        @(negedge clk); w_we = 1; w_in_sel = IN_AW'(i); w_out_sel = OUT_AW'(o); w_data = WW'(v);
        @(negedge clk); w_we = 0;
    endtask

    task automatic put_b(int o, int v);
        @(negedge clk); b_we = 1; b_sel = OUT_AW'(o); b_data = BW'(v);
        @(negedge clk); b_we = 0;
    endtask

    task automatic put_x(int i, int v);
        @(negedge clk); x_we = 1; x_sel = IN_AW'(i); x_data = DW'(v);
        @(negedge clk); x_we = 0;
    endtask

    task automatic run_layer(string tag);
        req_tag = tag;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (N_IN + 4) @(negedge clk);
    endtask

    int bias_pat [N_OUT] = '{-1, -16, -17, 15, 16, 2047, 2048, -2048, -2049, 100};

    initial begin
        // R1: reset state checked each cycle while rst_n is low
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R3: mixed-sign values
        for (int i = 0; i < N_IN; i++) begin
            put_x(i, rnd(128));
            for (int o = 0; o < N_OUT; o++) put_w(i, o, rnd(128));
        end
        for (int o = 0; o < N_OUT; o++) put_b(o, rnd(4096));
        run_layer("R3");

        // R4: zero input so outputs show bias scaling, rounding and saturation
        for (int i = 0; i < N_IN; i++) put_x(i, 0);
        for (int o = 0; o < N_OUT; o++) put_b(o, bias_pat[o]);
        run_layer("R4");

        // R5: full-scale sums, positive on even lanes, negative on odd lanes
        for (int i = 0; i < N_IN; i++) begin
            put_x(i, 127);
            for (int o = 0; o < N_OUT; o++) put_w(i, o, (o % 2 == 0) ? 127 : -128);
        end
        for (int o = 0; o < N_OUT; o++) put_b(o, 0);
        run_layer("R5");

        // R7: a second start in mid-run must be ignored
        req_tag = "R7";
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (5) @(negedge clk);
        start = 1;
        @(negedge clk); start = 0;
        repeat (N_IN + 4) @(negedge clk);

        // R2: reload some weights and biases, as after retraining
        for (int o = 0; o < N_OUT; o++) begin
            put_w(o, o, -3 * o);
            put_b(o, 37 * o - 160);
        end
        for (int i = 0; i < N_IN; i++) put_x(i, rnd(16));
        run_layer("R2");

        // R8: outputs hold while idle
        repeat (20) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule